// File: doc/BRIEF.md
# Reservation Monitor for Paired Load-Reserve / Conditional-Store Accesses

This block sits in front of a small word memory shared by several requesters. It lets them build atomic read-modify-write sequences from two accesses. A reserving load reads a word and marks the requester's interest in that address. A conditional store later writes the word only if nothing has disturbed that interest in between. Ordinary loads and stores pass through as well. The block tells each requester, one cycle after its access is accepted, what it read and whether its conditional store took effect.

Each requester owns one reservation slot, made of a valid flag and an address. Writes to an address clear the slots that watch it. These writes are an accepted conditional store or an ordinary store. Accesses arriving in the same cycle are accepted one per cycle by a rotating-priority arbiter. Only one of two racing conditional stores to the same word can therefore win. A requester keeps its request asserted until it sees its grant.

Top module: `resv_tracker`

## Requirements
- R1: After reset, every reservation is invalid, every memory word reads as zero, and no grant or response is asserted while no request is pending.
- R2: An ordinary load (op code 0) returns the addressed word on the granted port's `rsp_data` slot. `rsp_valid` is set for that port only, one cycle after the grant, and the other ports' data slots are zero.
- R3: A reserving load (op code 2) returns the addressed word and records a valid reservation on that address for the issuing port.
- R4: A conditional store (op code 3) issued by a port holding a valid reservation on the same address writes the word and reports `rsp_sc_ok` = 1.
- R5: A conditional store whose port holds no reservation, or holds one on another address, leaves memory unchanged and reports `rsp_sc_ok` = 0.
- R6: An accepted conditional store invalidates every other port's reservation on that address.
- R7: An ordinary store (op code 1) writes the word and invalidates every reservation, of any port, on that address.
- R8: Any conditional store, whether it succeeds or fails, invalidates the issuing port's own reservation.
- R9: A new reserving load from a port replaces that port's earlier reservation.
- R10: At most one request is granted per cycle, only to a port that requests. Priority rotates to the port after the last granted one. A request that is not granted stays pending until granted. Of several same-cycle conditional stores to one reserved address, only the first one granted succeeds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_PORTS | Per-port request pending |
| req_op | input | 2*N_PORTS | Per-port op: 0 load, 1 store, 2 reserving load, 3 conditional store |
| req_addr | input | ADDR_W*N_PORTS | Per-port word address |
| req_data | input | DATA_W*N_PORTS | Per-port write data |
| req_grant | output | N_PORTS | One-hot grant, same cycle as the request |
| rsp_valid | output | N_PORTS | Response strobe, one cycle after grant |
| rsp_data | output | DATA_W*N_PORTS | Read data for loads, zero otherwise |
| rsp_sc_ok | output | N_PORTS | Conditional store took effect |

## Verification
The bench aims at the cases where the reservation logic is easiest to get wrong:
- A second conditional store after a successful one. If own-slot clearing were missed, it would succeed twice.
- Two or three ports reserving one word and then storing to it conditionally in the same cycle. A missing cross-invalidation would let more than one of them write.
- An ordinary store landing between a reserving load and its conditional store. A monitor that ignores plain stores would let the conditional store go through.
- A conditional store to an address other than the one reserved, and a re-reservation that moves a port to a new address. An address-blind or non-replacing slot would accept a stale pairing.

After each such case, a following load checks that a failed store left memory untouched.

// File: rtl/resv_pkg.sv
package resv_pkg;
    localparam int OP_W = 2;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD      = 2'd0,
        OP_STORE     = 2'd1,
        OP_LOADRES   = 2'd2,
        OP_STORECOND = 2'd3
    } op_e;
endpackage

// File: rtl/resv_rr_arbiter.sv
module resv_rr_arbiter #(
    parameter int N     = 3,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] gidx,
    output logic             any
);
    typedef struct packed {
        logic [IDX_W-1:0] ptr;
    } arb_st_t;

    arb_st_t st_d, st_q;
    int      cand;

    always_comb begin
        st_d  = st_q;
        grant = '0;
        gidx  = '0;
        any   = 1'b0;
        cand  = 0;
        for (int k = 0; k < N; k++) begin
            cand = (int'(st_q.ptr) + k) % N;
            if (!any && req[cand]) begin
                any         = 1'b1;
                grant[cand] = 1'b1;
                gidx        = IDX_W'(cand);
            end
        end
        if (any) begin
            st_d.ptr = (gidx == IDX_W'(N - 1)) ? '0 : gidx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/resv_slot_table.sv
module resv_slot_table
    import resv_pkg::*;
#(
    parameter int N      = 3,
    parameter int ADDR_W = 4,
    parameter int IDX_W  = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_valid,
    input  logic [IDX_W-1:0]  win_idx,
    input  op_e               win_op,
    input  logic [ADDR_W-1:0] win_addr,
    output logic              sc_hit
);
    typedef struct packed {
        logic [N-1:0]             vld;
        logic [N-1:0][ADDR_W-1:0] adr;
    } tab_t;

    tab_t tab_d, tab_q;

    always_comb begin
        tab_d  = tab_q;
        sc_hit = tab_q.vld[win_idx] && (tab_q.adr[win_idx] == win_addr);
        if (win_valid) begin
            unique case (win_op)
                OP_LOADRES: begin
                    tab_d.vld[win_idx] = 1'b1;
                    tab_d.adr[win_idx] = win_addr;
                end
                OP_STORE: begin
                    for (int j = 0; j < N; j++) begin
                        if (tab_q.adr[j] == win_addr) tab_d.vld[j] = 1'b0;
                    end
                end
                OP_STORECOND: begin
                    if (sc_hit) begin
                        for (int j = 0; j < N; j++) begin
                            if (tab_q.adr[j] == win_addr) tab_d.vld[j] = 1'b0;
                        end
                    end
                    tab_d.vld[win_idx] = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tab_q <= '0;
        else        tab_q <= tab_d;
    end
endmodule

// File: rtl/resv_word_store.sv
module resv_word_store #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] word;
    } mem_t;

    mem_t mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        rdata = mem_q.word[addr];
        if (we) mem_d.word[addr] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end
endmodule

// File: rtl/resv_tracker.sv
module resv_tracker
    import resv_pkg::*;
#(
    parameter int N_PORTS = 3,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_PORTS-1:0]          req_valid,
    input  logic [N_PORTS*OP_W-1:0]     req_op,
    input  logic [N_PORTS*ADDR_W-1:0]   req_addr,
    input  logic [N_PORTS*DATA_W-1:0]   req_data,
    output logic [N_PORTS-1:0]          req_grant,
    output logic [N_PORTS-1:0]          rsp_valid,
    output logic [N_PORTS*DATA_W-1:0]   rsp_data,
    output logic [N_PORTS-1:0]          rsp_sc_ok
);
    localparam int IDX_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;

    typedef struct packed {
        logic [N_PORTS-1:0]             vld;
        logic [N_PORTS-1:0][DATA_W-1:0] data;
        logic [N_PORTS-1:0]             ok;
    } rsp_t;

    rsp_t              rsp_d, rsp_q;
    logic [IDX_W-1:0]  gidx;
    logic              any;
    op_e               win_op;
    logic [ADDR_W-1:0] win_addr;
    logic [DATA_W-1:0] win_data;
    logic [DATA_W-1:0] rd_word;
    logic              sc_hit;
    logic              wr_en;

    resv_rr_arbiter #(.N(N_PORTS), .IDX_W(IDX_W)) arb_i (
        .clk(clk), .rst_n(rst_n), .req(req_valid),
        .grant(req_grant), .gidx(gidx), .any(any)
    );

    always_comb begin
        win_op   = op_e'(req_op[int'(gidx)*OP_W +: OP_W]);
        win_addr = req_addr[int'(gidx)*ADDR_W +: ADDR_W];
        win_data = req_data[int'(gidx)*DATA_W +: DATA_W];
        wr_en    = any && ((win_op == OP_STORE) ||
                           (win_op == OP_STORECOND && sc_hit));
    end

    resv_slot_table #(.N(N_PORTS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) tab_i (
        .clk(clk), .rst_n(rst_n), .win_valid(any), .win_idx(gidx),
        .win_op(win_op), .win_addr(win_addr), .sc_hit(sc_hit)
    );

    resv_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) mem_i (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .addr(win_addr),
        .wdata(win_data), .rdata(rd_word)
    );

    always_comb begin
        rsp_d     = '0;
        rsp_d.vld = req_grant;
        if (any) begin
            if (win_op == OP_LOAD || win_op == OP_LOADRES)
                rsp_d.data[gidx] = rd_word;
            if (win_op == OP_STORECOND)
                rsp_d.ok[gidx] = sc_hit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.vld;
    assign rsp_data  = rsp_q.data;
    assign rsp_sc_ok = rsp_q.ok;
endmodule

// File: rtl/resv_tracker_chk.sv
module resv_tracker_chk
    import resv_pkg::*;
#(
    parameter int N_PORTS = 3,
    parameter int ADDR_W  = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [N_PORTS-1:0]        req_valid,
    input logic [N_PORTS*OP_W-1:0]   req_op,
    input logic [N_PORTS*ADDR_W-1:0] req_addr,
    input logic [N_PORTS-1:0]        req_grant,
    input logic [N_PORTS-1:0]        rsp_valid,
    input logic [N_PORTS-1:0]        rsp_sc_ok
);
    logic [ADDR_W-1:0]  g_addr, gaddr_q, prev_addr_q;
    logic [OP_W-1:0]    g_op, gop_q;
    logic [N_PORTS-1:0] gport_q, prev_port_q;
    logic               prev_ok_q;

    always_comb begin
        g_addr = '0;
        g_op   = '0;
        for (int i = 0; i < N_PORTS; i++) begin
            if (req_grant[i]) begin
                g_addr = req_addr[i*ADDR_W +: ADDR_W];
                g_op   = req_op[i*OP_W +: OP_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gaddr_q     <= '0;
            gop_q       <= '0;
            gport_q     <= '0;
            prev_ok_q   <= 1'b0;
            prev_addr_q <= '0;
            prev_port_q <= '0;
        end else begin
            gaddr_q <= g_addr;
            gop_q   <= g_op;
            gport_q <= req_grant;
            if (rsp_valid != '0) begin
                prev_ok_q   <= (rsp_sc_ok != '0);
                prev_addr_q <= gaddr_q;
                prev_port_q <= gport_q;
            end
        end
    end

    assert_one_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_grant));

    assert_grant_to_requester_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grant & ~req_valid) == '0);

    assert_rsp_after_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grant != '0) |=> (rsp_valid == $past(req_grant)));

    assert_no_rsp_without_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grant == '0) |=> (rsp_valid == '0));

    assert_ok_only_for_condstore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_sc_ok != '0) |-> ((rsp_sc_ok == rsp_valid) && (gop_q == OP_STORECOND)));

    assert_no_double_win_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((rsp_sc_ok != '0) && prev_ok_q && (prev_addr_q == gaddr_q))
            |-> (prev_port_q == gport_q));
endmodule

bind resv_tracker resv_tracker_chk #(.N_PORTS(N_PORTS), .ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_grant(req_grant), .rsp_valid(rsp_valid),
    .rsp_sc_ok(rsp_sc_ok)
);

// File: tb/resv_tracker_tb_top.sv
module resv_tracker_tb_top;
    localparam int N  = 3;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int WATCHDOG = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [N-1:0]    req_valid;
    logic [N*2-1:0]  req_op;
    logic [N*AW-1:0] req_addr;
    logic [N*DW-1:0] req_data;
    logic [N-1:0]    req_grant, rsp_valid, rsp_sc_ok;
    logic [N*DW-1:0] rsp_data;

    resv_tracker #(.N_PORTS(N), .ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_grant(req_grant),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_sc_ok(rsp_sc_ok)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // reference state
    logic [DW-1:0] m_mem [1<<AW];
    logic          m_v [N];
    logic [AW-1:0] m_a [N];
    int            m_ptr;

    // pending requests
    logic          p_v [N];
    int            p_op [N];
    logic [AW-1:0] p_a [N];
    logic [DW-1:0] p_d [N];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input int p, input int op, input int a, input int d);
        p_v[p]  = 1'b1;
        p_op[p] = op;
        p_a[p]  = AW'(a);
        p_d[p]  = DW'(d);
    endtask

    task automatic run_cycle(input string tag);
        int            eg;
        logic [N-1:0]  e_grant;
        logic [N*DW-1:0] e_data;
        logic [N-1:0]  e_ok;
        logic          hit;
        for (int i = 0; i < N; i++) begin
            req_valid[i]          = p_v[i];
            req_op[i*2 +: 2]      = 2'(p_op[i]);
            req_addr[i*AW +: AW]  = p_a[i];
            req_data[i*DW +: DW]  = p_d[i];
        end
        #1;
        eg = -1;
        for (int k = 0; k < N; k++) begin
            if (eg < 0 && p_v[(m_ptr + k) % N]) eg = (m_ptr + k) % N;
        end
        e_grant = '0;
        e_data  = '0;
        e_ok    = '0;
        if (eg >= 0) begin
            e_grant[eg] = 1'b1;
            case (p_op[eg])
                0: e_data[eg*DW +: DW] = m_mem[p_a[eg]];
                1: begin
                    m_mem[p_a[eg]] = p_d[eg];
                    for (int j = 0; j < N; j++) if (m_a[j] == p_a[eg]) m_v[j] = 1'b0;
                end
                2: begin
                    e_data[eg*DW +: DW] = m_mem[p_a[eg]];
                    m_v[eg] = 1'b1;
                    m_a[eg] = p_a[eg];
                end
                default: begin
                    hit = m_v[eg] && (m_a[eg] == p_a[eg]);
                    if (hit) begin
                        m_mem[p_a[eg]] = p_d[eg];
                        for (int j = 0; j < N; j++) if (m_a[j] == p_a[eg]) m_v[j] = 1'b0;
                    end
                    m_v[eg]  = 1'b0;
                    e_ok[eg] = hit;
                end
            endcase
            m_ptr  = (eg + 1) % N;
            p_v[eg] = 1'b0;
        end
        chk({tag, " R10 grant"}, 64'(req_grant), 64'(e_grant));
        @(posedge clk);
        @(negedge clk);
        cycles++;
        chk({tag, " R2 rsp_valid"}, 64'(rsp_valid), 64'(e_grant));
        chk({tag, " R2 rsp_data"}, 64'(rsp_data), 64'(e_data));
        chk({tag, " sc status"}, 64'(rsp_sc_ok), 64'(e_ok));
    endtask

    task automatic drain(input string tag);
        logic busy;
        busy = 1'b1;
        while (busy) begin
            busy = 1'b0;
            for (int i = 0; i < N; i++) if (p_v[i]) busy = 1'b1;
            if (busy) run_cycle(tag);
        end
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", WATCHDOG, WATCHDOG);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        req_valid = '0; req_op = '0; req_addr = '0; req_data = '0;
        for (int i = 0; i < (1 << AW); i++) m_mem[i] = '0;
        for (int i = 0; i < N; i++) begin
            m_v[i] = 1'b0; m_a[i] = '0; p_v[i] = 1'b0;
            p_op[i] = 0; p_a[i] = '0; p_d[i] = '0;
        end
        m_ptr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: idle after reset
        run_cycle("R1 idle");
        put(0, 0, 3, 0);                drain("R1 load of cleared word");
        put(1, 3, 2, 8'h55);            drain("R1 R5 condstore without reservation");
        put(1, 0, 2, 0);                drain("R5 word unchanged");

        // R3 / R4 / R7
        put(2, 1, 5, 8'h11);            drain("R7 plain store");
        put(0, 2, 5, 0);                drain("R3 reserving load");
        put(0, 3, 5, 8'h22);            drain("R4 condstore success");
        put(0, 0, 5, 0);                drain("R4 word written");

        // R8
        put(0, 3, 5, 8'h33);            drain("R8 second condstore fails");
        put(0, 0, 5, 0);                drain("R8 word not rewritten");

        // R6 with same-cycle reservations
        put(0, 2, 6, 0); put(1, 2, 6, 0); drain("R10 R3 concurrent reserve");
        put(0, 3, 6, 8'h44);            drain("R6 first condstore wins");
        put(1, 3, 6, 8'h45);            drain("R6 other reservation cancelled");
        put(2, 0, 6, 0);                drain("R6 word holds winner");

        // R7 clearing by plain store
        put(2, 2, 7, 0);                drain("R7 reserve");
        put(1, 1, 7, 8'h09);            drain("R7 plain store hits reserved word");
        put(2, 3, 7, 8'h77);            drain("R7 condstore after plain store fails");

        // R9 replacement
        put(1, 2, 8, 0); drain("R9 reserve a");
        put(1, 2, 9, 0); drain("R9 reserve b");
        put(1, 3, 8, 8'h88); drain("R9 old address dropped");
        put(1, 2, 8, 0); drain("R9 reserve a again");
        put(1, 2, 9, 0); drain("R9 reserve b again");
        put(1, 3, 9, 8'h99); drain("R9 new address succeeds");

        // R5 other address
        put(2, 2, 10, 0);               drain("R5 reserve");
        put(2, 3, 11, 8'hAA);           drain("R5 condstore other address");
        put(2, 0, 11, 0);               drain("R5 no write");

        // R10 three-way race
        put(0, 2, 12, 0); put(1, 2, 12, 0); put(2, 2, 12, 0); drain("R10 reserve all");
        put(0, 3, 12, 8'hC0); put(1, 3, 12, 8'hC1); put(2, 3, 12, 8'hC2);
        drain("R10 R6 same-cycle condstores");
        put(0, 0, 12, 0);               drain("R10 single winner value");

        // constrained random traffic on a few hot addresses
        for (int n = 0; n < 3000; n++) begin
            for (int i = 0; i < N; i++) begin
                if (!p_v[i] && ($urandom % 100) < 60)
                    put(i, int'($urandom % 4), int'($urandom % 4), int'($urandom % 256));
            end
            run_cycle("RND");
        end
        drain("RND tail");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule